// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block is a parallel I/O controller that sits on a small CPU bus. It has three 8-bit ports, here called east (A), west (B) and split (C). The split port is divided into an upper nibble and a lower nibble. The CPU reaches it through an 8-bit data bus, active-low select, read and write strobes, and a 2-bit address. A control register sets the direction of four port groups. A second command form, written to the same address, sets or clears one bit of the split port.

Port pins are modelled as separate input, output and output-enable vectors, with no tristate pins. Only unhandshaked operation is built. The mode fields for the other operating styles are stored and read back, but they have no effect on the ports.

Writes take effect when the write strobe rises. That edge is synchronised into the single system clock. Reads are combinational and are driven while select and read are both low.

Top module: `ppio_ctrl`

## Requirements
- R1: The address selects the target: 0 is port A, 1 is port B, 2 is port C and 3 is the control register. A transfer happens only while `cs_n` is low, and a write strobe with `cs_n` high changes nothing.
- R2: `dout_en` is low and `dout` is 0 whenever `cs_n` is high, or `rd_n` and `wr_n` are both high.
- R3: After synchronous reset the control register reads 9Bh, every output-enable bit is 0 and every output latch is 0.
- R4: A control word with bit 7 = 1 sets the directions, where 1 means input. Bit 4 controls port A, bit 1 port B, bit 3 the upper nibble of C and bit 0 the lower nibble of C. An output group has all its `*_oe` bits at 1, and an input group has them at 0.
- R5: A control word with bit 7 = 0 is a single-bit command. Bits 3:1 index the port C bit and bit 0 is its new value. Bits 6:4 are ignored, and the control register and all other latch bits stay unchanged.
- R6: Every control word with bit 7 = 1 clears the A, B and C output latches to 0.
- R7: A read of address 3 returns bit 7 as 1 and bits 6:0 as stored, including the mode bits 6:5 and 2.
- R8: A read of a port returns the live input pin for bits in an input group and the output latch for bits in an output group.
- R9: A data write loads the whole output latch of the addressed port within 3 clock cycles after `wr_n` rises. Latches hold their value in every cycle that has no committed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, acts on its rising edge |
| addr | input | 2 | Target select |
| din | input | 8 | CPU write data |
| dout | output | 8 | CPU read data, 0 when not driven |
| dout_en | output | 1 | Read data valid, drive enable for the bus |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
Two functions can fall in the same cycle: the latch clear caused by a mode word, and the loading of port data values written just before that word. Each pass of the mode table first fills all three latches with a pattern and then writes a new mode word. The latches must then read 0 at the port outputs, even for groups that stay outputs.

The split port also takes two kinds of change: whole-byte writes and single-bit commands. The bench mixes the two and judges each command by the one affected bit. It also checks that the control readback is unchanged afterwards.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] SEL_A   = 2'd0;
  localparam logic [ADDR_W-1:0] SEL_B   = 2'd1;
  localparam logic [ADDR_W-1:0] SEL_C   = 2'd2;
  localparam logic [ADDR_W-1:0] SEL_CTL = 2'd3;
  localparam logic [PORT_W-1:0] CTL_RESET = 8'h9B;
  // control word bit positions the port decode depends on
  localparam int B_CLO  = 0;
  localparam int B_PB   = 1;
  localparam int B_CHI  = 3;
  localparam int B_PA   = 4;
  localparam int B_FLAG = 7;
endpackage

// File: rtl/ppio_bus_sync.sv
module ppio_bus_sync #(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          commit,
  output logic [AW-1:0] c_addr,
  output logic [DW-1:0] c_data
);
  typedef struct packed {
    logic          cs_n;
    logic          wr_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } samp_t;

  samp_t s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '{cs_n: 1'b1, wr_n: 1'b1, addr: '0, data: '0};
      s2 <= '{cs_n: 1'b1, wr_n: 1'b1, addr: '0, data: '0};
    end else begin
      s1 <= '{cs_n: cs_n, wr_n: wr_n, addr: addr, data: din};
      s2 <= s1;
    end
  end

  // rising strobe seen between the older and newer sample
  assign commit = !s2.wr_n && s1.wr_n && !s2.cs_n;
  assign c_addr = s2.addr;
  assign c_data = s2.data;
endmodule

// File: rtl/ppio_ctl_reg.sv
module ppio_ctl_reg
  import ppio_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 8,
  parameter int IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit,
  input  logic [AW-1:0] c_addr,
  input  logic [DW-1:0] c_data,
  output logic [DW-1:0] ctl,
  output logic          mode_wr,
  output logic          bit_wr,
  output logic [IW-1:0] bit_idx,
  output logic          bit_val
);
  logic to_ctl;
  assign to_ctl  = commit && (c_addr == SEL_CTL);
  assign mode_wr = to_ctl && c_data[B_FLAG];
  assign bit_wr  = to_ctl && !c_data[B_FLAG];
  assign bit_idx = c_data[IW:1];
  assign bit_val = c_data[0];

  always_ff @(posedge clk) begin
    if (rst)          ctl <= CTL_RESET;
    else if (mode_wr) ctl <= c_data;
  end
endmodule

// File: rtl/ppio_port.sv
module ppio_port #(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          bit_en,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  input  logic [W-1:0]  dir_in,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  lat_q,
  output logic [W-1:0]  oe,
  output logic [W-1:0]  rd_val
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr)
        lat_q[i] <= 1'b0;
      else if (wr_en)
        lat_q[i] <= wr_data[i];
      else if (bit_en && (bit_idx == IW'(i)))
        lat_q[i] <= bit_val;
    end
    assign oe[i]     = !dir_in[i];
    assign rd_val[i] = dir_in[i] ? pin_in[i] : lat_q[i];
  end
endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
  import ppio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cs_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic [1:0]  addr,
  input  logic [7:0]  din,
  output logic [7:0]  dout,
  output logic        dout_en,
  input  logic [7:0]  pa_in,
  output logic [7:0]  pa_out,
  output logic [7:0]  pa_oe,
  input  logic [7:0]  pb_in,
  output logic [7:0]  pb_out,
  output logic [7:0]  pb_oe,
  input  logic [7:0]  pc_in,
  output logic [7:0]  pc_out,
  output logic [7:0]  pc_oe
);
  localparam int W  = PORT_W;
  localparam int IW = $clog2(W);
  localparam int HW = W / 2;

  logic          commit;
  logic [1:0]    c_addr;
  logic [W-1:0]  c_data;
  logic [W-1:0]  ctl;
  logic          mode_wr, bit_wr, bit_val;
  logic [IW-1:0] bit_idx;
  logic [W-1:0]  rd_a, rd_b, rd_c;
  logic [W-1:0]  dir_a, dir_b, dir_c;

  ppio_bus_sync #(.AW(ADDR_W), .DW(W)) u_sync (
    .clk, .rst, .cs_n, .wr_n, .addr, .din,
    .commit, .c_addr, .c_data
  );

  ppio_ctl_reg #(.AW(ADDR_W), .DW(W)) u_ctl (
    .clk, .rst, .commit, .c_addr, .c_data,
    .ctl, .mode_wr, .bit_wr, .bit_idx, .bit_val
  );

  assign dir_a = {W{ctl[B_PA]}};
  assign dir_b = {W{ctl[B_PB]}};
  assign dir_c = {{HW{ctl[B_CHI]}}, {HW{ctl[B_CLO]}}};

  ppio_port #(.W(W)) u_pa (
    .clk, .rst, .clr(mode_wr),
    .wr_en(commit && c_addr == SEL_A), .wr_data(c_data),
    .bit_en(1'b0), .bit_idx('0), .bit_val(1'b0),
    .dir_in(dir_a), .pin_in(pa_in),
    .lat_q(pa_out), .oe(pa_oe), .rd_val(rd_a)
  );

  ppio_port #(.W(W)) u_pb (
    .clk, .rst, .clr(mode_wr),
    .wr_en(commit && c_addr == SEL_B), .wr_data(c_data),
    .bit_en(1'b0), .bit_idx('0), .bit_val(1'b0),
    .dir_in(dir_b), .pin_in(pb_in),
    .lat_q(pb_out), .oe(pb_oe), .rd_val(rd_b)
  );

  ppio_port #(.W(W)) u_pc (
    .clk, .rst, .clr(mode_wr),
    .wr_en(commit && c_addr == SEL_C), .wr_data(c_data),
    .bit_en(bit_wr), .bit_idx(bit_idx), .bit_val(bit_val),
    .dir_in(dir_c), .pin_in(pc_in),
    .lat_q(pc_out), .oe(pc_oe), .rd_val(rd_c)
  );

  assign dout_en = !cs_n && !rd_n;

  always_comb begin
    dout = '0;
    if (dout_en) begin
      unique case (addr)
        SEL_A:   dout = rd_a;
        SEL_B:   dout = rd_b;
        SEL_C:   dout = rd_c;
        default: dout = {1'b1, ctl[W-2:0]};
      endcase
    end
  end
endmodule

// File: rtl/ppio_ctrl_chk.sv
module ppio_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic [1:0] addr,
  input logic [7:0] dout,
  input logic       dout_en,
  input logic [7:0] pa_out,
  input logic [7:0] pb_out,
  input logic [7:0] pc_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_oe,
  input logic       commit,
  input logic [1:0] c_addr,
  input logic [7:0] c_data
);
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cs_n || (rd_n && wr_n)) |-> (!dout_en && dout == 8'h00)); // R2

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00 &&
                    pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00)); // R3

  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (commit && c_addr == 2'd3 && c_data[7]) |=>
      (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00)); // R6

  AST_CTL_TOP_BIT: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && addr == 2'd3) |-> dout[7]); // R7

  AST_BIT_CMD_ONE: assert property (@(posedge clk) disable iff (rst)
    (commit && c_addr == 2'd3 && !c_data[7]) |=>
      ($countones(pc_out ^ $past(pc_out)) <= 1 && $stable(pa_out) &&
       $stable(pb_out) && $stable(pc_oe) && $stable(pa_oe))); // R5

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out))); // R9
endmodule

bind ppio_ctrl ppio_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
  .dout(dout), .dout_en(dout_en),
  .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
  .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe),
  .commit(commit), .c_addr(c_addr), .c_data(c_data)
);

// File: tb/sim_ppio_ctrl.sv
module sim_ppio_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic dout_en;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ppio_ctrl u0 (.*);

  localparam int NM = 7;
  localparam logic [7:0] MODES [NM] =
    '{8'h80, 8'h9B, 8'h90, 8'h83, 8'h89, 8'h8A, 8'hE1};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [1:0] a, input logic [7:0] d, input logic csn = 1'b0);
    @(negedge clk);
    cs_n = csn; addr = a; din = d; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic brd(input logic [1:0] a, output logic [7:0] v, output logic en);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1;
    v = dout; en = dout_en;
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, ea, eb, ec;
    logic en;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3 reset state
    chk("R3 pa_oe", pa_oe, 8'h00);
    chk("R3 pb_oe", pb_oe, 8'h00);
    chk("R3 pc_oe", pc_oe, 8'h00);
    chk("R3 pc_out", pc_out, 8'h00);
    brd(2'd3, v, en);
    chk("R3 ctl read", v, 8'h9B);
    chk("R1 read enable", {7'd0, en}, 8'h01);
    // R2 bus quiet
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #1;
    chk("R2 cs high", {dout_en, dout[6:0]}, 8'h00);
    cs_n = 1'b0; rd_n = 1'b1; #1;
    chk("R2 rd wr high", {dout_en, dout[6:0]}, 8'h00);
    cs_n = 1'b1;

    // table of mode words
    for (int i = 0; i < NM; i++) begin
      bwr(2'd0, 8'hA5); bwr(2'd1, 8'h3C); bwr(2'd2, 8'hF0);
      bwr(2'd3, MODES[i]);
      chk("R6 clear A", pa_out, 8'h00);
      chk("R6 clear B", pb_out, 8'h00);
      chk("R6 clear C", pc_out, 8'h00);
      bwr(2'd0, 8'h5A); bwr(2'd1, 8'hC3); bwr(2'd2, 8'h96);
      chk("R9 latch A", pa_out, 8'h5A);
      pa_in = 8'h0F ^ 8'(i); pb_in = 8'hE7 ^ 8'(i); pc_in = 8'h69 ^ 8'(i * 17);
      ea = MODES[i][4] ? pa_in : 8'h5A;
      eb = MODES[i][1] ? pb_in : 8'hC3;
      ec = {MODES[i][3] ? pc_in[7:4] : 4'h9, MODES[i][0] ? pc_in[3:0] : 4'h6};
      brd(2'd0, v, en); chk("R8 read A", v, ea);
      brd(2'd1, v, en); chk("R8 read B", v, eb);
      brd(2'd2, v, en); chk("R8 read C", v, ec);
      chk("R4 oe A", pa_oe, MODES[i][4] ? 8'h00 : 8'hFF);
      chk("R4 oe B", pb_oe, MODES[i][1] ? 8'h00 : 8'hFF);
      chk("R4 oe C", pc_oe, {{4{!MODES[i][3]}}, {4{!MODES[i][0]}}});
      brd(2'd3, v, en); chk("R7 ctl read", v, MODES[i] | 8'h80);
    end

    // R5 single-bit commands on port C, all outputs
    bwr(2'd3, 8'h80);
    bwr(2'd2, 8'h00);
    bwr(2'd3, 8'h7B);  // bits 6:4 junk, index 5, set
    chk("R5 set bit5", pc_out, 8'h20);
    brd(2'd3, v, en); chk("R5 ctl unchanged", v, 8'h80);
    bwr(2'd3, 8'h01);  // index 0 set
    chk("R5 set bit0", pc_out, 8'h21);
    bwr(2'd3, 8'h0F);  // index 7 set
    chk("R5 set bit7", pc_out, 8'hA1);
    bwr(2'd3, 8'h4A);  // index 5 clear
    chk("R5 clear bit5", pc_out, 8'h81);
    chk("R5 port A untouched", pa_out, 8'h00);

    // R1 write with select high is ignored
    bwr(2'd0, 8'h77);
    chk("R1 write A", pa_out, 8'h77);
    bwr(2'd0, 8'h11, 1'b1);
    chk("R1 cs high ignored", pa_out, 8'h77);
    bwr(2'd3, 8'h00, 1'b1);
    brd(2'd3, v, en); chk("R1 cs high ctl", v, 8'h80);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule